// File: doc/BRIEF.md
# Settle-Detecting Parallel Bus Capture

This block takes a multi-bit word from a source that updates it now and then, with no clock relationship to this block. Each bit has already gone through its own two-flop synchroniser. Bits that are synchronised one by one can land on different clocks while the source is changing, so a word read during a transition may be a mix of old and new bits. This block does not try to sample every cycle. It watches for any change on the bus, waits until the bus has stayed the same for a fixed number of clocks, and then captures the whole word once.

A change detector compares the bus with its copy from the previous clock. A settle controller counts the quiet clocks that follow the end of a burst of changes. It raises a one-cycle sample strobe when the count reaches the settle length, and then returns to idle. The output register loads the settled word on that strobe and keeps it at all other times. Ten settle clocks must take longer than the longest source transition. They must also be much shorter than the time the source holds each value, so the clock frequency is chosen to fit between those two limits.

Top module: `settle_capture`

## Requirements
- R1: `changeStrobe` is 1 in exactly those cycles where `busIn` differs in at least one bit from the value it had at the previous rising clock edge.
- R2: If a change is registered at clock edge k and no further change occurs, `sampleStrobe` is 1 during the single cycle between edges k+SETTLE_N and k+SETTLE_N+1. It is 0 in every other cycle.
- R3: `dataOut` takes the settled bus word at the edge that ends the `sampleStrobe` cycle, and holds its value at every other edge.
- R4: A change that arrives before the settle count completes restarts the wait. No strobe occurs until SETTLE_N quiet edges have followed the most recent change.
- R5: After a strobe, no further strobe occurs and `dataOut` stays unchanged for as long as the bus stays unchanged.
- R6: Synchronous reset (`rst` = 1 at a rising edge) clears the stored previous bus copy, the settle state and `dataOut` to 0. With `busIn` at 0 after reset, both strobes are therefore 0.
- R7: A change confined to any single bit position of the bus is detected and leads to a capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| busIn | input | DATA_W | Bus word, already synchronised bit by bit |
| dataOut | output | DATA_W | Most recently captured settled word |
| changeStrobe | output | 1 | Bus differs from its previous-cycle copy |
| sampleStrobe | output | 1 | One-cycle pulse when the bus has settled |

## Verification
`changeStrobe` is combinational, so the bench checks it 1 ns after it drives a new word on a falling edge. The change is registered at the next rising edge, k. From then on the bench samples on each falling edge, index j counting edges after k. `sampleStrobe` must be 1 only at j = SETTLE_N, and `dataOut` must show the new word from j = SETTLE_N+1 onwards and the old word before that. For the restart case, the index is reset at the second change, so the expected pulse moves to SETTLE_N edges after that change. Quiet-hold checks keep sampling falling edges for tens of cycles after a capture.

// File: rtl/settle_capture_pkg.sv
package settle_capture_pkg;

  // Strobes from the settle controller to the datapath.
  typedef struct packed {
    logic load;   // capture the settled word at the coming edge
  } ctrlStrobes_t;

endpackage

// File: rtl/settle_datapath.sv
module settle_datapath
  import settle_capture_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] busIn,
  input  ctrlStrobes_t      ctrl,
  output logic              changeOut,
  output logic [DATA_W-1:0] dataOut
);

  logic [DATA_W-1:0] prevBus;
  logic [DATA_W-1:0] bitDiff;

  // Previous-cycle copy of the bus.
  always_ff @(posedge clk) begin
    if (rst) prevBus <= '0;
    else     prevBus <= busIn;
  end

  // Per-bit difference, reduced to one change flag.
  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_diff
      assign bitDiff[gi] = busIn[gi] ^ prevBus[gi];
    end
  endgenerate

  assign changeOut = |bitDiff;

  // Capture register: loads the copy that has been stable through the
  // settle window, not the live bus, so a change in the strobe cycle
  // cannot corrupt the captured word.
  always_ff @(posedge clk) begin
    if (rst)            dataOut <= '0;
    else if (ctrl.load) dataOut <= prevBus;
  end

  // R1
  unchanged_copy_chk: assert property (@(posedge clk) disable iff (rst)
    !changeOut |=> (prevBus == $past(prevBus)));

  // R3
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.load |=> (dataOut == $past(prevBus)));

  // R3
  hold_value_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl.load |=> $stable(dataOut));

endmodule

// File: rtl/settle_control.sv
module settle_control
  import settle_capture_pkg::*;
#(
  parameter int SETTLE_N = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         changeIn,
  output ctrlStrobes_t ctrl,
  output logic         sampleOut
);

  localparam int CNT_W = (SETTLE_N < 1) ? 1 : $clog2(SETTLE_N + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_N);

  logic             lastChg;
  logic [CNT_W-1:0] quietCnt;
  logic [CNT_W-1:0] quietCntNext;

  // Quiet-cycle counter: starts on the falling side of the change flag,
  // advances while quiet, and drops back to 0 on any change or after the
  // final count so the pulse cannot repeat.
  always_comb begin
    if (changeIn)               quietCntNext = '0;
    else if (lastChg)           quietCntNext = CNT_W'(1);
    else if (quietCnt == CNT_LAST) quietCntNext = '0;
    else if (quietCnt != '0)    quietCntNext = quietCnt + CNT_W'(1);
    else                        quietCntNext = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lastChg  <= 1'b0;
      quietCnt <= '0;
    end else begin
      lastChg  <= changeIn;
      quietCnt <= quietCntNext;
    end
  end

  assign sampleOut = (quietCnt == CNT_LAST);
  assign ctrl.load = sampleOut;

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    sampleOut |=> !sampleOut);

  // R4
  change_blocks_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    changeIn |=> !sampleOut);

  // R5
  pulse_needs_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sampleOut) |-> !$past(changeIn));

endmodule

// File: rtl/settle_capture.sv
module settle_capture
  import settle_capture_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SETTLE_N = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              changeStrobe,
  output logic              sampleStrobe
);

  ctrlStrobes_t ctrl;
  logic         changeFlag;
  logic         sampleFlag;

  settle_datapath #(.DATA_W(DATA_W)) u_path (
    .clk       (clk),
    .rst       (rst),
    .busIn     (busIn),
    .ctrl      (ctrl),
    .changeOut (changeFlag),
    .dataOut   (dataOut)
  );

  settle_control #(.SETTLE_N(SETTLE_N)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .changeIn  (changeFlag),
    .ctrl      (ctrl),
    .sampleOut (sampleFlag)
  );

  assign changeStrobe = changeFlag;
  assign sampleStrobe = sampleFlag;

  // R6
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (dataOut == '0) && !sampleStrobe);

endmodule

// File: tb/settle_capture_test.sv
module settle_capture_test;

  localparam int DW = 8;
  localparam int SN = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] busIn = '0;
  logic [DW-1:0] dataOut;
  logic          changeStrobe;
  logic          sampleStrobe;

  int checks = 0;
  int failures = 0;
  logic [DW-1:0] expData = '0;
  logic [DW-1:0] lastBus = '0;

  settle_capture #(.DATA_W(DW), .SETTLE_N(SN)) uut (
    .clk(clk), .rst(rst), .busIn(busIn),
    .dataOut(dataOut), .changeStrobe(changeStrobe), .sampleStrobe(sampleStrobe)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Follow the settle window after a change registered at the next edge.
  task automatic followWindow(input string req, input logic [DW-1:0] v);
    for (int j = 0; j <= SN + 2; j++) begin
      @(negedge clk);
      chk({req, " strobe"}, 32'(sampleStrobe), 32'(j == SN));
      chk({req, " data"}, 32'(dataOut), 32'((j <= SN) ? expData : v));
      if (j == 0) chk({req, " change cleared"}, 32'(changeStrobe), 32'd0);
    end
    expData = v;
    lastBus = v;
  endtask

  // R1 R2 R3: drive a new word and track the capture timing.
  task automatic applyAndSettle(input string req, input logic [DW-1:0] v);
    @(negedge clk);
    busIn = v;
    #1;
    chk({req, " R1 change"}, 32'(changeStrobe), 32'(v != lastBus));
    followWindow(req, v);
  endtask

  // R4: second change before the settle count completes.
  task automatic restartCase(input logic [DW-1:0] v1, input logic [DW-1:0] v2, input int gap);
    @(negedge clk);
    busIn = v1;
    for (int j = 0; j < gap; j++) begin
      @(negedge clk);
      chk("R4 early no strobe", 32'(sampleStrobe), 32'd0);
      chk("R4 early data held", 32'(dataOut), 32'(expData));
    end
    busIn = v2;
    #1;
    chk("R4 second change", 32'(changeStrobe), 32'd1);
    followWindow("R4 restart", v2);
  endtask

  // R5: bus quiet after capture.
  task automatic quietHold(input int cycles);
    for (int j = 0; j < cycles; j++) begin
      @(negedge clk);
      chk("R5 no repeat strobe", 32'(sampleStrobe), 32'd0);
      chk("R5 data held", 32'(dataOut), 32'(expData));
    end
  endtask

  // R6: reset state.
  task automatic resetCase();
    rst = 1'b1;
    busIn = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R6 reset data", 32'(dataOut), 32'd0);
    chk("R6 reset sample", 32'(sampleStrobe), 32'd0);
    chk("R6 reset change", 32'(changeStrobe), 32'd0);
    rst = 1'b0;
    expData = '0;
    lastBus = '0;
    @(negedge clk);
    chk("R6 idle after reset", 32'(sampleStrobe), 32'd0);
  endtask

  // R7: walk a single changed bit across every position.
  task automatic bitWalk();
    for (int i = 0; i < DW; i++)
      applyAndSettle("R7 bit", expData ^ DW'(1 << i));
  endtask

  initial begin
    resetCase();
    applyAndSettle("R2 first", 8'hA5);
    quietHold(30);
    applyAndSettle("R3 all bits", 8'h5A);
    applyAndSettle("R3 to zero", 8'h00);
    applyAndSettle("R3 to ones", 8'hFF);
    restartCase(8'h3C, 8'hC3, 5);
    restartCase(8'h11, 8'h22, SN - 1);
    restartCase(8'h44, 8'h88, 1);
    quietHold(20);
    bitWalk();
    quietHold(15);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule